// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block models a synchronous static RAM that reads without an output register. A parameterised word array is split into two byte lanes. All control inputs are sampled on the rising clock edge. Three chip-select inputs together decide whether the device responds. A cycle starts on either of two address strobes. One strobe belongs to the processor side and the other to the controller side. The processor strobe has priority, and it has its own gating rule. After a cycle starts, a 2-bit burst counter holds the low address bits. The counter steps through the four words of an aligned group whenever the advance input is low.

Writes come from one of two sources. A global write enable writes every lane. A byte write enable writes the lanes that are picked by per-lane select inputs. Read data comes straight out of the array at the registered address. It appears in the same cycle that the address register updates. The data bus is split into pad-side signals: input data, output data and a drive enable. The drive enable is gated without a clock by an active-low output enable. It is held off on the first clock after the device leaves the deselected state.

Top module: `sburst_sram`

## Requirements
- R1: A cycle start selects the device only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A start with any other combination deselects the device. While the device is deselected, `dq_oe` is 0 and nothing is written.
- R2: A processor start (`strb_cpu_n`=0 with `ce1_n`=0) loads the full address. `addr[1:0]` goes into the burst counter. Once the device is selected and not masked, the word at that address appears on `dq_out` after that same edge.
- R3: If both strobes are low in the same cycle, only the processor strobe acts. The write enables of that cycle are therefore not applied.
- R4: When `ce1_n`=1, the processor strobe has no effect, and the burst address and selection are kept. The controller strobe (`strb_ctl_n`=0 with `strb_cpu_n`=1) starts a cycle whatever the value of `ce1_n`.
- R5: While the device is selected and no strobe starts a cycle, `adv_n`=0 steps the counter modulo 4 (00,01,10,11,00) and leaves the upper address bits unchanged. `adv_n`=1 holds the address.
- R6: `gw_n`=0 writes both lanes from `dq_in`, whatever `bwe_n` and `bsel_n` are.
- R7: When `gw_n`=1 and `bwe_n`=0, lane i (`dq_in[8i+7:8i]`) is written only if `bsel_n[i]`=0. When `bwe_n`=1, `bsel_n` has no effect.
- R8: A processor-start cycle never writes. A controller-start cycle on a selected device writes, using the enables sampled in that same cycle. Writes go to the address that is in effect after the edge.
- R9: `dq_oe` is 1 only during a selected read cycle (one with no write at its edge) while `oe_n`=0. It follows `oe_n` with no clock.
- R10: On the first clock after a start moves the device from deselected to selected, `dq_oe` stays 0. From the next read cycle on it follows R9.
- R11: After reset the device is deselected, `dq_oe` is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte write selects, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus (0 when not driving) |
| dq_oe | output | 1 | Bus drive enable for the pad |

## Verification
Writes and address, counter and mask changes take effect at the rising edge where their inputs are sampled. Because reads need no extra register, the word read from the new address is valid on `dq_out` before the next falling edge. The bench applies its inputs at a falling edge and updates its model at the next rising edge. It then compares `dq_oe` and `dq_out` at the falling edge after that, so every result is checked exactly one edge after its stimulus. The output-enable path has no clock, so it is checked one nanosecond after `oe_n` changes, with no clock edge in between.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     strb_cpu_n,
  input  logic                     strb_ctl_n,
  input  logic                     adv_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [LANES-1:0]         bsel_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        cnt_q;
  logic              sel_q, rd_q, mask_q;
  logic [LANES-1:0]  lane_we;

  wire chip_on = !ce1_n && ce2 && !ce3_n;
  wire go_cpu  = !strb_cpu_n && !ce1_n;
  wire go_ctl  = !strb_ctl_n && strb_cpu_n;
  wire go      = go_cpu || go_ctl;
  wire bump    = !go && sel_q && !adv_n;
  wire live    = go ? chip_on : sel_q;

  wire [1:0]        cnt_nx = go ? addr[1:0] : (bump ? cnt_q + 2'd1 : cnt_q);
  wire [HI_W-1:0]   hi_nx  = go ? addr[ADDR_W-1:2] : hi_q;
  wire [ADDR_W-1:0] wr_a   = {hi_nx, cnt_nx};
  wire [ADDR_W-1:0] rd_a   = {hi_q, cnt_q};

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_we[i] = !gw_n || (!bwe_n && !bsel_n[i]);
    if (!live || go_cpu) lane_we = '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk)
      if (lane_we[g]) mem[wr_a][g*LANE_W +: LANE_W] <= dq_in[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      mask_q <= 1'b0;
      hi_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sel_q  <= live;
      rd_q   <= live && (lane_we == '0);
      mask_q <= go && chip_on && !sel_q;
      hi_q   <= hi_nx;
      cnt_q  <= cnt_nx;
    end

  assign dq_oe  = sel_q && rd_q && !mask_q && !oe_n;
  assign dq_out = dq_oe ? mem[rd_a] : '0;
endmodule

module sburst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              sel_q,
  input logic [ADDR_W-3:0] hi_q,
  input logic [1:0]        cnt_q,
  input logic              dq_oe
);
  wire st  = (!strb_cpu_n && !ce1_n) || (!strb_ctl_n && strb_cpu_n);
  wire on  = !ce1_n && ce2 && !ce3_n;

  // R2
  cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !ce1_n) |=> (cnt_q == $past(addr[1:0])) && (hi_q == $past(addr[ADDR_W-1:2])));

  // R5
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st && sel_q && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)) && $stable(hi_q));

  // R5
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st && adv_n) |=> $stable(cnt_q) && $stable(hi_q));

  // R4
  cpu_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && !strb_cpu_n && adv_n) |=> $stable(sel_q) && $stable(cnt_q) && $stable(hi_q));

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !on) |=> !sel_q && !dq_oe);

  // R10
  first_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st && on && !sel_q) |=> !dq_oe);
endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
  .sel_q(sel_q), .hi_q(hi_q), .cnt_q(cnt_q), .dq_oe(dq_oe)
);

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [1:0] bsel_n = 2'b11;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int runs = 0, fails = 0;

  logic [DW-1:0] m_mem [1<<AW];
  logic [AW-1:0] m_a = '0;
  logic m_sel = 1'b0, m_rd = 1'b0, m_mask = 1'b0;

  always #10 clk = ~clk;

  sburst_sram #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8'(a * 3 + 1), 8'(a ^ 8'hA5)};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic go_c, go_t, on, live;
    logic [AW-1:0] ea;
    logic [1:0] wl;
    go_c = !strb_cpu_n && !ce1_n;
    go_t = !strb_ctl_n && strb_cpu_n;
    on   = !ce1_n && ce2 && !ce3_n;
    if (go_c || go_t) begin
      ea = addr; live = on;
    end else begin
      ea = m_a; live = m_sel;
      if (m_sel && !adv_n) ea[1:0] = ea[1:0] + 2'd1;
    end
    wl = !gw_n ? 2'b11 : (!bwe_n ? ~bsel_n : 2'b00);
    if (!live || go_c) wl = 2'b00;
    if (wl[0]) m_mem[ea][7:0]  = dq_in[7:0];
    if (wl[1]) m_mem[ea][15:8] = dq_in[15:8];
    m_mask = (go_c || go_t) && on && !m_sel;
    m_sel  = live;
    m_rd   = live && (wl == 2'b00);
    m_a    = ea;
  endtask

  task automatic compare(input string req);
    logic eo;
    eo = m_sel && m_rd && !m_mask && !oe_n;
    check(req, {15'd0, dq_oe}, {15'd0, eo});
    if (eo) check(req, dq_out, m_mem[m_a]);
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 2'b11;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R11
    check("R11", {15'd0, dq_oe}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {15'd0, dq_oe}, 16'd0);

    // R6 R8: preload via controller strobe with global write
    oe_n = 1'b1;
    for (int a = 0; a < (1 << AW); a++) begin
      idle(); strb_ctl_n = 1'b0; addr = AW'(a); gw_n = 1'b0; bsel_n = 2'b11; dq_in = pat(AW'(a));
      cyc("R8");
    end
    idle(); oe_n = 1'b0;

    // R2: processor read, flow-through
    strb_cpu_n = 1'b0; addr = 8'h21;
    cyc("R2");
    check("R2", dq_out, pat(8'h21));

    // R5: burst wraps within the group
    idle(); adv_n = 1'b0;
    cyc("R5"); check("R5", dq_out, pat(8'h22));
    cyc("R5"); check("R5", dq_out, pat(8'h23));
    cyc("R5"); check("R5", dq_out, pat(8'h20));
    adv_n = 1'b1;
    cyc("R5"); check("R5", dq_out, pat(8'h20));

    // R4: processor strobe ignored with ce1_n high
    idle(); ce1_n = 1'b1; strb_cpu_n = 1'b0; addr = 8'h77;
    cyc("R4"); check("R4", dq_out, pat(8'h20));

    // R9: output enable without clock
    idle(); oe_n = 1'b1; #1;
    check("R9", {15'd0, dq_oe}, 16'd0);
    oe_n = 1'b0; #1;
    check("R9", {15'd0, dq_oe}, 16'd1);
    check("R9", dq_out, pat(8'h20));

    // R4 R1: controller strobe with ce1_n high deselects
    idle(); ce1_n = 1'b1; strb_ctl_n = 1'b0; addr = 8'h40;
    cyc("R4"); check("R1", {15'd0, dq_oe}, 16'd0);

    // R10: first read after deselect is masked, then drives
    idle(); strb_cpu_n = 1'b0; addr = 8'h45;
    cyc("R10"); check("R10", {15'd0, dq_oe}, 16'd0);
    idle();
    cyc("R10"); check("R10", dq_out, pat(8'h45));

    // R1: ce2 low start deselects
    idle(); ce2 = 1'b0; strb_cpu_n = 1'b0; addr = 8'h46;
    cyc("R1"); check("R1", {15'd0, dq_oe}, 16'd0);

    // R3 R8: both strobes with global write, nothing written
    idle(); strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; gw_n = 1'b0; addr = 8'h50; dq_in = 16'hDEAD;
    oe_n = 1'b1;
    cyc("R3");
    idle(); oe_n = 1'b0;
    cyc("R3"); check("R3", dq_out, pat(8'h50));

    // R7: one lane by select
    idle(); strb_ctl_n = 1'b0; bwe_n = 1'b0; bsel_n = 2'b10; addr = 8'h51; dq_in = 16'hBEEF;
    oe_n = 1'b1;
    cyc("R7");
    idle(); oe_n = 1'b0;
    cyc("R7"); check("R7", dq_out, {pat(8'h51)[15:8], 8'hEF});

    // R7: selects ignored without byte enable
    idle(); strb_ctl_n = 1'b0; bsel_n = 2'b00; addr = 8'h52; dq_in = 16'h1234;
    cyc("R7"); check("R7", dq_out, pat(8'h52));

    // R6: global write overrides selects
    idle(); strb_ctl_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bsel_n = 2'b11; addr = 8'h53;
    dq_in = 16'hC0DE; oe_n = 1'b1;
    cyc("R6");
    idle(); oe_n = 1'b0;
    cyc("R6"); check("R6", dq_out, 16'hC0DE);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic wr;
      addr       = AW'($urandom);
      ce1_n      = ($urandom % 6) == 0;
      ce2        = ($urandom % 8) != 0;
      ce3_n      = ($urandom % 8) == 0;
      strb_cpu_n = ($urandom % 4) != 0;
      strb_ctl_n = ($urandom % 4) != 0;
      adv_n      = ($urandom % 2) != 0;
      gw_n       = ($urandom % 10) != 0;
      bwe_n      = ($urandom % 4) != 0;
      bsel_n     = 2'($urandom);
      dq_in      = DW'($urandom);
      wr         = !gw_n || !bwe_n;
      oe_n       = wr ? 1'b1 : (($urandom % 5) == 0);
      cyc("R5/R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule